// File: doc/BRIEF.md
# DRAM Row Refresh Sequencer with Multiplexed Address Bus

This block sits between a requester and a DRAM cell array of 2^ROW_BITS rows by 2^COL_BITS columns (512 by 512 by default). The requester presents a full word address, which is ROW_BITS + COL_BITS wide, together with a direction flag and write data. The block splits that address and sends its two halves over one narrow address bus in turn. The low half selects the row and goes out first, under the row strobe. The high half selects the column and goes out on the next cycle, under the column strobe. A single-cycle ready pulse tells the requester that the access has finished. On a read, the returned word is valid during that pulse.

A free-running timer raises a refresh demand every REFRESH_INTERVAL cycles. When the bus is idle, a pending demand is served ahead of any waiting request. A refresh opens the row named by an internal refresh counter and reads it. On the next cycle the block writes that row back, still under the row strobe, and the column strobe stays low throughout. The counter then advances and wraps past the last row to zero, so successive refreshes walk through the whole array. An access that has already started always runs to completion first. Every operation ends with both strobes low before the next one may begin.

Top module: `dram_refresh_mux`

## Requirements
- R1: While reset is held (active low), the row strobe, column strobe, write enable and ready outputs are all 0.
- R2: An access begins with one cycle in which the row strobe is 1, the column strobe is 0, and the address bus carries request address bits [ROW_BITS-1:0].
- R3: The cycle directly after the row cycle raises the column strobe while the row strobe stays 1, and the bus carries address bits [ROW_BITS+COL_BITS-1:ROW_BITS]. In that cycle, write enable equals the request's write flag and, on a write, the write data is driven. The column strobe is never 1 for two cycles in a row.
- R4: Ready is 1 for exactly one cycle per access, in the cycle after the column cycle. On a read, the data output in that cycle equals the array data presented during the column cycle.
- R5: The column strobe is 1 only while the row strobe is 1. After the row strobe falls, both strobes stay 0 for at least one cycle before any new operation, and both are 0 while ready is 1.
- R6: A row refresh is a cycle with the row strobe at 1 and write enable at 0 (read), followed by a cycle with the row strobe at 1 and write enable at 1 (write back). Both cycles carry the same row on the bus, and the column strobe is 0 throughout.
- R7: The first refresh after reset is applied to row 0. Each later refresh is applied to the next row, and the row after the last row (511 by default) is 0.
- R8: With no requests, refresh operations start exactly REFRESH_INTERVAL cycles apart. Under continuous requests, a pending refresh is taken before the next request, but never in the middle of an access, so starts stay within 3 cycles of that spacing.
- R9: Ready is 0 in every cycle in which the row strobe is 1, including refresh cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Word address, row in low bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Read data, valid with ready |
| arr_rdata | input | DATA_W | Data returned by the array in the column cycle |
| arr_addr | output | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| arr_ras | output | 1 | Row strobe |
| arr_cas | output | 1 | Column strobe |
| arr_we | output | 1 | Array write enable |
| arr_wdata | output | DATA_W | Data to the array |

## Verification
The bound checker checks the strobe ordering on every cycle. It holds that the column strobe is only asserted under an open row, never lasts two cycles, and follows a row cycle. It also holds that ready is a lone pulse on an idle bus, that a falling row strobe is followed by a recovery cycle, and that each write-back addresses the row that was just read. Other behaviours involve arithmetic over many operations, and only the bench scenarios can show them. These are the split of each address into its halves, read data matching the array model, refresh rows walking upward and wrapping after the last row, and the exact or bounded spacing of refreshes with and without contending requests.

// File: rtl/dram_refresh_mux_pkg.sv
package dram_refresh_mux_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_ROW,
      SEQ_COL,
      SEQ_DONE,
      SEQ_REF_RD,
      SEQ_REF_WB,
      SEQ_REF_REC
   } seq_state_t;

   function automatic int max_width(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/drm_refresh_timer.sv
module drm_refresh_timer #(
   parameter int INTERVAL = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic pending
);
   localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // a fresh tick takes precedence over the clear of an older demand
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
      end else if (tick) begin
         pending <= 1'b1;
      end else if (clear) begin
         pending <= 1'b0;
      end
   end
endmodule

// File: rtl/drm_row_counter.sv
module drm_row_counter #(
   parameter int ROW_BITS = 9,
   parameter int ROWS     = 512
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   output logic [ROW_BITS-1:0] row
);
   localparam int FULL = 2 ** ROW_BITS;

   generate
      if (ROWS == FULL) begin : g_natural_wrap
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               row <= '0;
            end else if (step) begin
               row <= row + 1'b1;
            end
         end
      end else begin : g_compare_wrap
         localparam logic [ROW_BITS-1:0] TOP = ROW_BITS'(ROWS - 1);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               row <= '0;
            end else if (step) begin
               row <= (row == TOP) ? '0 : row + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/drm_sequencer.sv
module drm_sequencer
   import dram_refresh_mux_pkg::*;
#(
   parameter int ROW_BITS = 9,
   parameter int COL_BITS = 9,
   parameter int DATA_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         req_we,
   input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
   input  logic [DATA_W-1:0]            req_wdata,
   output logic                         req_ready,
   output logic [DATA_W-1:0]            req_rdata,
   input  logic [DATA_W-1:0]            arr_rdata,
   input  logic                         ref_pending,
   input  logic [ROW_BITS-1:0]          ref_row,
   output logic                         ref_clear,
   output logic                         ref_step,
   output logic [max_width(ROW_BITS, COL_BITS)-1:0] arr_addr,
   output logic                         arr_ras,
   output logic                         arr_cas,
   output logic                         arr_we,
   output logic [DATA_W-1:0]            arr_wdata
);
   localparam int ADDR_W = ROW_BITS + COL_BITS;
   localparam int BUS_W  = max_width(ROW_BITS, COL_BITS);

   seq_state_t          state_q, state_d;
   logic [ADDR_W-1:0]   lat_addr;
   logic                lat_we;
   logic [DATA_W-1:0]   lat_wdata;
   logic [BUS_W-1:0]    row_half, col_half, ref_half;
   logic                accept;

   assign accept    = (state_q == SEQ_IDLE) && !ref_pending && req_valid;
   assign ref_clear = (state_q == SEQ_IDLE) && ref_pending;
   assign ref_step  = (state_q == SEQ_REF_REC);

   assign row_half = BUS_W'(lat_addr[ROW_BITS-1:0]);
   assign col_half = BUS_W'(lat_addr[ADDR_W-1:ROW_BITS]);
   assign ref_half = BUS_W'(ref_row);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: begin
            if (ref_pending) begin
               state_d = SEQ_REF_RD;
            end else if (req_valid) begin
               state_d = SEQ_ROW;
            end
         end
         SEQ_ROW:     state_d = SEQ_COL;
         SEQ_COL:     state_d = SEQ_DONE;
         SEQ_DONE:    state_d = SEQ_IDLE;
         SEQ_REF_RD:  state_d = SEQ_REF_WB;
         SEQ_REF_WB:  state_d = SEQ_REF_REC;
         SEQ_REF_REC: state_d = SEQ_IDLE;
         default:     state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_addr  <= '0;
         lat_we    <= 1'b0;
         lat_wdata <= '0;
      end else if (accept) begin
         lat_addr  <= req_addr;
         lat_we    <= req_we;
         lat_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_rdata <= '0;
      end else if (state_q == SEQ_COL && !lat_we) begin
         req_rdata <= arr_rdata;
      end
   end

   always_comb begin
      arr_ras   = 1'b0;
      arr_cas   = 1'b0;
      arr_we    = 1'b0;
      arr_addr  = '0;
      arr_wdata = '0;
      req_ready = 1'b0;
      unique case (state_q)
         SEQ_ROW: begin
            arr_ras  = 1'b1;
            arr_addr = row_half;
         end
         SEQ_COL: begin
            arr_ras   = 1'b1;
            arr_cas   = 1'b1;
            arr_addr  = col_half;
            arr_we    = lat_we;
            arr_wdata = lat_we ? lat_wdata : '0;
         end
         SEQ_DONE:   req_ready = 1'b1;
         SEQ_REF_RD: begin
            arr_ras  = 1'b1;
            arr_addr = ref_half;
         end
         SEQ_REF_WB: begin
            arr_ras  = 1'b1;
            arr_we   = 1'b1;
            arr_addr = ref_half;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dram_refresh_mux.sv
module dram_refresh_mux
   import dram_refresh_mux_pkg::*;
#(
   parameter int ROW_BITS         = 9,
   parameter int COL_BITS         = 9,
   parameter int DATA_W           = 8,
   parameter int REFRESH_ROWS     = 2 ** ROW_BITS,
   parameter int REFRESH_INTERVAL = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         req_we,
   input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
   input  logic [DATA_W-1:0]            req_wdata,
   output logic                         req_ready,
   output logic [DATA_W-1:0]            req_rdata,
   input  logic [DATA_W-1:0]            arr_rdata,
   output logic [max_width(ROW_BITS, COL_BITS)-1:0] arr_addr,
   output logic                         arr_ras,
   output logic                         arr_cas,
   output logic                         arr_we,
   output logic [DATA_W-1:0]            arr_wdata
);
   localparam int MIN_INTERVAL = 8;

   generate
      if (ROW_BITS < 1 || COL_BITS < 1) begin : g_bad_split
         $error("row and column fields need at least one bit each");
      end
      if (REFRESH_ROWS < 1 || REFRESH_ROWS > 2 ** ROW_BITS) begin : g_bad_rows
         $error("REFRESH_ROWS must lie in 1 .. 2**ROW_BITS");
      end
      if (REFRESH_INTERVAL < MIN_INTERVAL) begin : g_bad_interval
         $error("REFRESH_INTERVAL too short to leave room for accesses");
      end
   endgenerate

   logic                ref_pending;
   logic                ref_clear;
   logic                ref_step;
   logic [ROW_BITS-1:0] ref_row;

   drm_refresh_timer #(
      .INTERVAL (REFRESH_INTERVAL)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (ref_clear),
      .pending (ref_pending)
   );

   drm_row_counter #(
      .ROW_BITS (ROW_BITS),
      .ROWS     (REFRESH_ROWS)
   ) rowcnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (ref_step),
      .row   (ref_row)
   );

   drm_sequencer #(
      .ROW_BITS (ROW_BITS),
      .COL_BITS (COL_BITS),
      .DATA_W   (DATA_W)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_we      (req_we),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .req_ready   (req_ready),
      .req_rdata   (req_rdata),
      .arr_rdata   (arr_rdata),
      .ref_pending (ref_pending),
      .ref_row     (ref_row),
      .ref_clear   (ref_clear),
      .ref_step    (ref_step),
      .arr_addr    (arr_addr),
      .arr_ras     (arr_ras),
      .arr_cas     (arr_cas),
      .arr_we      (arr_we),
      .arr_wdata   (arr_wdata)
   );
endmodule

// File: rtl/dram_refresh_mux_chk.sv
module dram_refresh_mux_chk #(
   parameter int BUS_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic [BUS_W-1:0] arr_addr,
   input logic             arr_ras,
   input logic             arr_cas,
   input logic             arr_we
);
   // R5
   cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_cas |-> arr_ras);

   // R3
   cas_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_cas |-> ($past(arr_ras) && !$past(arr_cas)));

   // R3
   cas_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_cas |=> !arr_cas);

   // R4
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // R5
   ready_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!arr_ras && !arr_cas));

   // R5
   recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(arr_ras) |=> !arr_ras);

   // R6
   writeback_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_ras && !arr_cas && arr_we) |->
         ($past(arr_ras) && !$past(arr_we) && !$past(arr_cas) && arr_addr == $past(arr_addr)));

   // R9
   ready_quiet_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_ras |-> !req_ready);
endmodule

bind dram_refresh_mux dram_refresh_mux_chk #(
   .BUS_W (dram_refresh_mux_pkg::max_width(ROW_BITS, COL_BITS))
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .arr_addr  (arr_addr),
   .arr_ras   (arr_ras),
   .arr_cas   (arr_cas),
   .arr_we    (arr_we)
);

// File: tb/dram_refresh_mux_tb_top.sv
module dram_refresh_mux_tb_top;
   localparam int RB  = 9;
   localparam int CB  = 9;
   localparam int DW  = 8;
   localparam int AW  = RB + CB;
   localparam int NROW = 2 ** RB;
   localparam int IVL = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic [DW-1:0] req_rdata;
   logic [DW-1:0] arr_rdata;
   logic [RB-1:0] arr_addr;
   logic          arr_ras, arr_cas, arr_we;
   logic [DW-1:0] arr_wdata;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dram_refresh_mux #(
      .ROW_BITS (RB), .COL_BITS (CB), .DATA_W (DW), .REFRESH_INTERVAL (IVL)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_we (req_we),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_ready (req_ready),
      .req_rdata (req_rdata), .arr_rdata (arr_rdata), .arr_addr (arr_addr),
      .arr_ras (arr_ras), .arr_cas (arr_cas), .arr_we (arr_we), .arr_wdata (arr_wdata)
   );

   function automatic logic [DW-1:0] cell_val(input int r, input int c);
      return DW'(r * 7 + c * 3 + 5);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // array model and bus monitor
   int  open_row = 0;
   int  seen_col = 0;
   bit  seen_we = 0;
   int  seen_wdata = 0;
   bit  p_ras = 0, p_cas = 0, p_we = 0;
   int  p_addr = 0;
   longint cyc = 0;
   longint last_ref = -1;
   int  ref_count = 0;
   int  exp_ref_row = 0;
   bit  exact_mode = 0;
   bit  wrap_seen = 0;

   assign arr_rdata = cell_val(open_row, int'(arr_addr));

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (arr_ras && !p_ras) begin
            open_row = int'(arr_addr);
            check(!arr_cas, "R2 no column strobe in row cycle", arr_cas, 0);
         end
         if (arr_ras)
            check(!req_ready, "R9 ready low while row open", req_ready, 0);
         if (p_cas)
            check(!arr_ras, "R5 row closes after column cycle", arr_ras, 0);
         if (arr_cas) begin
            check(p_ras && !p_cas, "R3 column follows row cycle", p_ras, 1);
            seen_col   = int'(arr_addr);
            seen_we    = arr_we;
            seen_wdata = int'(arr_wdata);
         end
         if (arr_ras && !arr_cas && arr_we) begin
            check(p_ras && !p_we && !p_cas, "R6 read precedes write back", p_we, 0);
            check(int'(arr_addr) == p_addr, "R6 write back same row", arr_addr, p_addr);
            check(int'(arr_addr) == exp_ref_row, "R7 refresh row order", arr_addr, exp_ref_row);
            if (exp_ref_row == 0 && ref_count > 0) wrap_seen = 1;
            if (last_ref >= 0) begin
               if (exact_mode)
                  check(cyc - 1 - last_ref == IVL, "R8 idle refresh spacing", cyc - 1 - last_ref, IVL);
               else
                  check((cyc - 1 - last_ref >= IVL - 3) && (cyc - 1 - last_ref <= IVL + 3),
                        "R8 busy refresh spacing", cyc - 1 - last_ref, IVL);
            end
            last_ref = cyc - 1;
            ref_count++;
            exp_ref_row = (exp_ref_row + 1) % NROW;
         end
      end
      p_ras  = arr_ras;
      p_cas  = arr_cas;
      p_we   = arr_we;
      p_addr = int'(arr_addr);
   end

   task automatic access(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
      int waited = 0;
      req_valid = 1'b1;
      req_we    = we;
      req_addr  = addr;
      req_wdata = wd;
      do begin
         @(negedge clk);
         waited++;
      end while (!req_ready && waited < 100);
      check(req_ready, "R4 ready pulse arrives", req_ready, 1);
      req_valid = 1'b0;
      check(open_row == int'(addr[RB-1:0]), "R2 row half on bus", open_row, addr[RB-1:0]);
      check(seen_col == int'(addr[AW-1:RB]), "R3 column half on bus", seen_col, addr[AW-1:RB]);
      check(seen_we == we, "R3 write enable in column cycle", seen_we, we);
      if (we)
         check(seen_wdata == int'(wd), "R3 write data driven", seen_wdata, wd);
      else
         check(req_rdata == cell_val(addr[RB-1:0], addr[AW-1:RB]), "R4 read data",
               req_rdata, cell_val(addr[RB-1:0], addr[AW-1:RB]));
      @(negedge clk);
      check(!req_ready, "R4 ready lasts one cycle", req_ready, 0);
   endtask

   task automatic wait_refs(input int n);
      int target = ref_count + n;
      while (ref_count < target) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(!arr_ras && !arr_cas && !arr_we && !req_ready, "R1 reset outputs quiet",
            {arr_ras, arr_cas, arr_we, req_ready}, 0);
      rst_n = 1'b1;
      wait_refs(1);
      check(wrap_seen == 0 && exp_ref_row == 1, "R7 first refresh is row 0", exp_ref_row, 1);
      exact_mode = 1;
      wait_refs(5);
      exact_mode = 0;
      // busy phase: back-to-back accesses over corner and walking addresses
      access(1'b0, '0, '0);
      access(1'b0, '1, '0);
      access(1'b1, AW'(NROW - 1), 8'hA5);
      access(1'b0, AW'((NROW - 1) << RB), '0);
      for (int b = 0; b < AW; b++) begin
         access(1'b0, AW'(1) << b, '0);
         access(1'b1, ~(AW'(1) << b), DW'(b * 11 + 1));
      end
      for (int k = 0; k < 40; k++)
         access(k[0], AW'(k * 6547 + 13), DW'(k * 29));
      // idle again until the row counter wraps
      wait_refs(2);
      exact_mode = 1;
      while (!wrap_seen) @(negedge clk);
      check(wrap_seen, "R7 counter wraps to row 0", wrap_seen, 1);
      wait_refs(2);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule